// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block merges the interrupt conditions of a UART into one interrupt request and a four-bit identification code. The processor reads that code to learn which condition needs service. Four conditions are inputs from the surrounding logic:

- a receive line error;
- receive data ready, meaning the holding register is full or the FIFO has reached its threshold;
- the transmit holding register or FIFO becoming empty;
- a modem-status change.

A fifth condition, the character timeout, is built inside the block. It is counted from character-time ticks while the receive FIFO holds data.

Each condition has its own enable bit. When several are active, only the most urgent enabled one is reported. The transmit-empty condition is latched. It is cleared either when the processor reads the identification code while that code shows transmit-empty, or when the transmit holding register is written. The interrupt request and the identification code are both registered, so they always change on the same rising clock edge.

The register file, the bus decoding and the logic that produces the conditions belong to the surrounding UART. This block only ranks the conditions, latches transmit-empty and reports the result.

Top module: `uart_irq_prio`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block enters its idle state. After that edge `irq` is 0 and `iid` is 4'b0001, which means nothing is pending.
- R2: A receive line error (`line_err`=1) with `src_en[2]`=1 is reported as `iid`=4'b0110. It outranks every other source.
- R3: Receive data ready (`rx_ready`=1) with `src_en[0]`=1 is reported as `iid`=4'b0100.
- R4: In FIFO mode (`fifo_mode`=1), while `rx_nonempty`=1, the block counts `char_tick` pulses. A cycle with `rx_push` or `rx_pop` restarts the count. After four ticks with neither, a timeout is pending and is reported as `iid`=4'b1100 when `src_en[0]`=1. The timeout stays pending until a push, a pop, an empty FIFO or leaving FIFO mode. The timeout never fires in character mode (`fifo_mode`=0). When receive data ready and the timeout are both pending, receive data ready is reported.
- R5: Transmit-empty is latched on the cycle `tx_empty` goes from 0 to 1. It is reported as `iid`=4'b0010 when `src_en[1]`=1. The edge detector treats `tx_empty` as 1 during reset, so a `tx_empty` that is already high at reset does not latch.
- R6: A cycle with `iid_rd`=1 clears the transmit-empty latch only if the registered `iid` shows 4'b0010 in that cycle. A read while another code is shown leaves the latch set. If the latch is set again by a new `tx_empty` rise in the same cycle as a clearing read, the new rise wins.
- R7: A cycle with `tx_write`=1 clears the transmit-empty latch. This takes precedence over a `tx_empty` rise in the same cycle.
- R8: A modem-status change (`modem_chg`=1) with `src_en[3]`=1 is reported as `iid`=4'b0000. It is the lowest priority.
- R9: With several enabled sources pending, the order from highest to lowest is line error, receive data ready, timeout, transmit-empty, modem change.
- R10: `irq` is 1 exactly when some enabled source is pending, and then `iid[0]`=0. A source whose enable bit is 0 has no effect on `irq` or `iid`. Bits of `src_en`: 0 receive data and timeout, 1 transmit-empty, 2 line error, 3 modem change.
- R11: A change on a level condition (`line_err`, `rx_ready`, `modem_chg`) or on `src_en` appears on `irq` and `iid` one rising edge later. A latched state (transmit-empty or timeout) appears one edge after that state is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_mode | input | 1 | 1 when the UART FIFOs are in use |
| src_en | input | 4 | Per-source enables: [0] receive data and timeout, [1] transmit-empty, [2] line error, [3] modem change |
| line_err | input | 1 | Receive line error condition (level) |
| rx_ready | input | 1 | Receive data ready or FIFO at threshold (level) |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_push | input | 1 | A character entered the receive FIFO this cycle |
| rx_pop | input | 1 | A character was read from the receive FIFO this cycle |
| char_tick | input | 1 | One-cycle pulse per character time |
| tx_empty | input | 1 | Transmit holding register or FIFO is empty (level) |
| tx_write | input | 1 | Transmit holding register written this cycle |
| modem_chg | input | 1 | Modem-status change condition (level) |
| iid_rd | input | 1 | Identification register read this cycle |
| irq | output | 1 | Registered interrupt request |
| iid | output | 4 | Registered identification code; bit 0 low when pending |

## Verification
The ranking is tried with each source alone, and then with the sources stacked so that removing the top one exposes the next. This separates a correct ladder from one with two rungs swapped. The transmit-empty latch is exercised three ways:
- read while showing its own code;
- read while a line error hides it;
- cleared by a holding-register write.

These cases separate a read-clear that looks at the displayed code from one that ignores it. The timeout is run to four ticks, interrupted by a push at three ticks and by a pop, and repeated in character mode, which shows whether the count restarts and whether the mode gate is applied. Every enabled condition is also raised with all enables off, to show that masking reaches both outputs.

// File: rtl/uart_irq_pkg.sv
// Package: shared codes and enable-bit positions for the UART interrupt block.
// Assumes: a 4-bit identification code whose bit 0 is low when an interrupt is pending.
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_NONE    = 4'b0001,
        IID_LINE    = 4'b0110,
        IID_RXDATA  = 4'b0100,
        IID_TIMEOUT = 4'b1100,
        IID_THRE    = 4'b0010,
        IID_MODEM   = 4'b0000
    } iid_code_e;

    localparam int NUM_SRC   = 4;
    localparam int EN_RXDATA = 0;
    localparam int EN_THRE   = 1;
    localparam int EN_LINE   = 2;
    localparam int EN_MODEM  = 3;

endpackage

// File: rtl/irq_char_timeout.sv
// Character-timeout detector. It counts character-time ticks while the receive
// FIFO holds data and no character moves in or out. The output goes high once
// LIMIT ticks have passed.
// Assumes: char_tick is a one-cycle pulse; the count restarts on a push, a pop,
// an empty FIFO, or when FIFO mode is off.
module irq_char_timeout #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic rx_nonempty,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic char_tick,
    output logic timeout_pend
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] tick_cnt;
    logic          restart;

    // Any receive activity, an empty FIFO or character mode restarts the count.
    assign restart = !fifo_mode || !rx_nonempty || rx_push || rx_pop;

    // Count ticks up to the limit, then hold there.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            tick_cnt <= '0;
        else if (char_tick && tick_cnt != LIM)
            tick_cnt <= tick_cnt + 1'b1;
    end

    assign timeout_pend = (tick_cnt == LIM);

    // The timeout never stays pending across a cycle in character mode.
    assert_timeout_fifo_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> !timeout_pend);

endmodule

// File: rtl/irq_thre_latch.sv
// Transmit-empty latch. It sets on the rising edge of the empty condition and
// clears on a holding-register write or on an identification read that shows
// the transmit-empty code.
// Assumes: the empty condition is treated as high during reset, so a buffer that
// is already empty at reset does not raise a request.
module irq_thre_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic tx_write,
    input  logic read_clear,
    output logic thre_pend
);
    logic empty_d;

    // Keep the previous empty level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) empty_d <= 1'b1;
        else        empty_d <= tx_empty;
    end

    // A write clears first, a new rise sets next, then a read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                    thre_pend <= 1'b0;
        else if (tx_write)             thre_pend <= 1'b0;
        else if (tx_empty && !empty_d) thre_pend <= 1'b1;
        else if (read_clear)           thre_pend <= 1'b0;
    end

    // A holding-register write always leaves the latch clear.
    assert_write_clears_thre_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> !thre_pend);

endmodule

// File: rtl/irq_prio_enc.sv
// Priority encoder. It picks the most urgent enabled source and gives its code.
// Assumes: all inputs are level conditions valid during the current cycle.
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               line_err,
    input  logic               rx_ready,
    input  logic               timeout_pend,
    input  logic               thre_pend,
    input  logic               modem_chg,
    output iid_code_e          code,
    output logic               pending
);
    // Walk the ladder from the most urgent source down.
    always_comb begin
        if (src_en[EN_LINE] && line_err)            code = IID_LINE;
        else if (src_en[EN_RXDATA] && rx_ready)     code = IID_RXDATA;
        else if (src_en[EN_RXDATA] && timeout_pend) code = IID_TIMEOUT;
        else if (src_en[EN_THRE] && thre_pend)      code = IID_THRE;
        else if (src_en[EN_MODEM] && modem_chg)     code = IID_MODEM;
        else                                        code = IID_NONE;
    end

    // A request exists whenever some enabled source is active.
    always_comb begin
        pending = (src_en[EN_LINE] && line_err) || (src_en[EN_RXDATA] && (rx_ready || timeout_pend))
               || (src_en[EN_THRE] && thre_pend) || (src_en[EN_MODEM] && modem_chg);
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Top of the UART interrupt controller. It ranks the enabled sources, latches
// transmit-empty and counts the character timeout, then registers the
// interrupt request and the identification code on the same edge.
// Assumes: synchronous active-low reset; iid_rd is a one-cycle read strobe that
// refers to the code currently on iid.
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int TIMEOUT_CHARS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_mode,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               line_err,
    input  logic               rx_ready,
    input  logic               rx_nonempty,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               char_tick,
    input  logic               tx_empty,
    input  logic               tx_write,
    input  logic               modem_chg,
    input  logic               iid_rd,
    output logic               irq,
    output logic [3:0]         iid
);
    logic      timeout_pend;
    logic      thre_pend;
    logic      read_clear;
    logic      pend_c;
    iid_code_e code_c;
    iid_code_e iid_q;
    logic      irq_q;

    irq_char_timeout #(.LIMIT(TIMEOUT_CHARS)) u_timeout (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_nonempty(rx_nonempty),
        .rx_push(rx_push), .rx_pop(rx_pop), .char_tick(char_tick), .timeout_pend(timeout_pend)
    );

    // A read clears transmit-empty only while its code is on display.
    assign read_clear = iid_rd && (iid_q == IID_THRE);

    irq_thre_latch u_thre (
        .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .tx_write(tx_write),
        .read_clear(read_clear), .thre_pend(thre_pend)
    );

    irq_prio_enc u_enc (
        .src_en(src_en), .line_err(line_err), .rx_ready(rx_ready), .timeout_pend(timeout_pend),
        .thre_pend(thre_pend), .modem_chg(modem_chg), .code(code_c), .pending(pend_c)
    );

    // Register the request and the code together so they never disagree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            iid_q <= IID_NONE;
        end else begin
            irq_q <= pend_c;
            iid_q <= code_c;
        end
    end

    assign irq = irq_q;
    assign iid = iid_q;

    // The request line and the pending bit of the code always agree.
    assert_irq_code_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (iid_q != IID_NONE));

    // An enabled line error is reported first on the following edge.
    assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en[EN_LINE] && line_err) |=> (iid_q == IID_LINE));

    // With every enable off, no request is raised.
    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en == '0) |=> !irq_q);

    // An enabled modem change is never left unreported.
    assert_modem_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en[EN_MODEM] && modem_chg) |=> irq_q);

endmodule

// File: tb/uart_irq_prio_test.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is stepped on every rising edge, and the
// design's outputs are compared with it on every falling edge. Directed checks
// at chosen points add precise expectations per requirement.
module uart_irq_prio_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_mode = 0, line_err = 0, rx_ready = 0, rx_nonempty = 0, rx_push = 0, rx_pop = 0;
    logic char_tick = 0, tx_empty = 1, tx_write = 0, modem_chg = 0, iid_rd = 0;
    logic [3:0] src_en = 4'b0000;
    logic irq;
    logic [3:0] iid;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit started = 0;
    bit done = 0;

    // Reference model state
    int  m_cnt = 0;
    bit  m_thre = 0;
    bit  m_prev = 1;
    int  e_iid = 1;
    bit  e_irq = 0;

    always #2.5 clk = ~clk;

    uart_irq_prio uut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .src_en(src_en), .line_err(line_err),
        .rx_ready(rx_ready), .rx_nonempty(rx_nonempty), .rx_push(rx_push), .rx_pop(rx_pop),
        .char_tick(char_tick), .tx_empty(tx_empty), .tx_write(tx_write), .modem_chg(modem_chg),
        .iid_rd(iid_rd), .irq(irq), .iid(iid)
    );

    // Reference model: outputs from the old state first, then the state update.
    always @(posedge clk) begin
        int n_iid;
        if (!rst_n) begin
            m_cnt = 0; m_thre = 0; m_prev = 1; e_iid = 1; e_irq = 0;
        end else begin
            if (src_en[2] && line_err)          n_iid = 6;
            else if (src_en[0] && rx_ready)     n_iid = 4;
            else if (src_en[0] && m_cnt == 4)   n_iid = 12;
            else if (src_en[1] && m_thre)       n_iid = 2;
            else if (src_en[3] && modem_chg)    n_iid = 0;
            else                                n_iid = 1;
            if (tx_write)                  m_thre = 0;
            else if (tx_empty && !m_prev)  m_thre = 1;
            else if (iid_rd && e_iid == 2) m_thre = 0;
            m_prev = tx_empty;
            if (!fifo_mode || !rx_nonempty || rx_push || rx_pop) m_cnt = 0;
            else if (char_tick && m_cnt < 4) m_cnt = m_cnt + 1;
            e_iid = n_iid;
            e_irq = (n_iid != 1);
        end
        started = 1;
    end

    // Compare with the model on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (irq !== e_irq || iid !== 4'(e_iid)) begin
                errors++;
                $display("FAIL %s: irq=%0b iid=%b expected irq=%0b iid=%b", cur_req, irq, iid, e_irq, 4'(e_iid));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string req, input bit x_irq, input logic [3:0] x_iid);
        checks++;
        if (irq !== x_irq || iid !== x_iid) begin
            errors++;
            $display("FAIL %s: irq=%0b iid=%b expected irq=%0b iid=%b", req, irq, iid, x_irq, x_iid);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        tick(3);
        expect_now("R1", 1'b0, 4'b0001);
        rst_n = 1;
        tick(2);
        expect_now("R1", 1'b0, 4'b0001);

        // R3 receive data ready alone, with R11 latency
        cur_req = "R3"; src_en = 4'b0001; rx_ready = 1;
        tick(1); expect_now("R3", 1'b1, 4'b0100);
        rx_ready = 0; tick(1); expect_now("R11", 1'b0, 4'b0001);

        // R2 line error over receive data (R9)
        cur_req = "R2"; src_en = 4'b0101; rx_ready = 1; line_err = 1;
        tick(1); expect_now("R2", 1'b1, 4'b0110);
        line_err = 0; tick(1); expect_now("R9", 1'b1, 4'b0100);
        rx_ready = 0; tick(1);

        // R5 transmit-empty on a rising edge of the empty condition
        cur_req = "R5"; src_en = 4'b0010; tx_empty = 0; tick(1);
        tx_empty = 1; tick(2); expect_now("R5", 1'b1, 4'b0010);

        // R6 read while the line error hides it leaves it set
        cur_req = "R6"; src_en = 4'b0110; line_err = 1; tick(1);
        expect_now("R6", 1'b1, 4'b0110);
        iid_rd = 1; tick(1); iid_rd = 0; line_err = 0; tick(1);
        expect_now("R6", 1'b1, 4'b0010);
        // R6 read while showing its own code clears it
        iid_rd = 1; tick(1); iid_rd = 0; tick(1);
        expect_now("R6", 1'b0, 4'b0001);

        // R7 a write clears the latch
        cur_req = "R7"; tx_empty = 0; tick(1); tx_empty = 1; tick(2);
        expect_now("R7", 1'b1, 4'b0010);
        tx_write = 1; tick(1); tx_write = 0; tick(1);
        expect_now("R7", 1'b0, 4'b0001);

        // R8 modem lowest, under transmit-empty (R9)
        cur_req = "R8"; tx_empty = 0; tick(1); tx_empty = 1; src_en = 4'b1010; modem_chg = 1; tick(2);
        expect_now("R9", 1'b1, 4'b0010);
        tx_write = 1; tick(1); tx_write = 0; tick(1);
        expect_now("R8", 1'b1, 4'b0000);
        modem_chg = 0; tick(1);

        // R4 timeout after four ticks in FIFO mode
        cur_req = "R4"; src_en = 4'b0001; fifo_mode = 1; rx_nonempty = 1;
        for (int i = 0; i < 4; i++) begin char_tick = 1; tick(1); char_tick = 0; tick(1); end
        tick(1); expect_now("R4", 1'b1, 4'b1100);
        rx_ready = 1; tick(1); expect_now("R9", 1'b1, 4'b0100); rx_ready = 0;
        rx_pop = 1; tick(1); rx_pop = 0; tick(1); expect_now("R4", 1'b0, 4'b0001);
        for (int i = 0; i < 3; i++) begin char_tick = 1; tick(1); char_tick = 0; tick(1); end
        rx_push = 1; tick(1); rx_push = 0;
        char_tick = 1; tick(1); char_tick = 0; tick(2); expect_now("R4", 1'b0, 4'b0001);
        fifo_mode = 0;
        for (int i = 0; i < 6; i++) begin char_tick = 1; tick(1); char_tick = 0; tick(1); end
        expect_now("R4", 1'b0, 4'b0001);
        rx_nonempty = 0;

        // R10 everything active but masked
        cur_req = "R10"; src_en = 4'b0000; line_err = 1; rx_ready = 1; modem_chg = 1;
        tx_empty = 0; tick(1); tx_empty = 1; tick(3);
        expect_now("R10", 1'b0, 4'b0001);
        src_en = 4'b1000; line_err = 0; rx_ready = 0; tick(1);
        expect_now("R10", 1'b1, 4'b0000);
        src_en = 4'b1010; tick(1); expect_now("R9", 1'b1, 4'b0010);
        modem_chg = 0; tx_write = 1; tick(1); tx_write = 0; tick(2);
        expect_now("R11", 1'b0, 4'b0001);

        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            finish_run();
        end
    end
endmodule